// File: doc/BRIEF.md
# SPI Target with Clock-Polarity Detection at Select

This block is the target side of an SPI link and needs no mode setting. When the active-low select input asserts, it samples the SCK level. A low SCK means a mode 0 host and a high SCK means a mode 3 host. In both modes it captures MOSI on rising SCK edges and changes MISO on falling edges, so one build serves either kind of host.

All SPI inputs are brought into the system clock domain through two-flop synchronisers, and the block detects SCK and select edges there. The word length and the bit order come from configuration inputs. Each received word appears on a parallel bus with a one-cycle valid strobe. The transmit word is taken from a parallel input when select asserts and again whenever a word completes.

The control is a three-state machine:
- **ST_IDLE**: select is inactive.
- **ST_WAIT_LEAD**: mode 3 was detected and the block waits for the first falling edge.
- **ST_ACTIVE**: bits are shifting.

The transitions are:
- **T_SEL_M0**: ST_IDLE to ST_ACTIVE when select asserts with SCK low.
- **T_SEL_M3**: ST_IDLE to ST_WAIT_LEAD when select asserts with SCK high.
- **T_LEAD**: ST_WAIT_LEAD to ST_ACTIVE on the first falling SCK edge.
- **T_DESEL**: any state to ST_IDLE when select deasserts. This transition takes priority over every other.

Top module: `spi_autopol_target`

## Requirements
- R1: While select has been inactive for three or more system-clock cycles, and directly after reset, miso_oe is 0 and rx_valid is 0.
- R2: When select asserts with SCK low (mode 0), miso_oe rises and MISO carries the first bit of the word before the first rising SCK edge.
- R3: When select asserts with SCK high (mode 3), miso_oe stays 0 until the first falling SCK edge. From that edge on, MISO carries the first bit of the word.
- R4: MOSI is sampled on each rising SCK edge. After the last bit of a word, rx_word holds the assembled word and rx_valid is 1 for exactly one system-clock cycle.
- R5: While MISO is driven, its value changes only after a falling SCK edge. It stays stable through the high phase of SCK.
- R6: When cfg_lsb_first is 0, the first bit on the wire in both directions is bit L-1 of the word. When cfg_lsb_first is 1, the first bit is bit 0.
- R7: The word length L equals cfg_len for values 1 to MAX_BITS. A cfg_len of 0, or any value above MAX_BITS, selects L = MAX_BITS. Bits of rx_word at positions L and above are 0.
- R8: tx_word is latched when select asserts and again in the cycle a word completes. The latched word is shifted out in the following word, back to back, with no gap in the SCK stream.
- R9: If select deasserts in the middle of a word, the partial word is discarded without an rx_valid pulse. The next selection starts at bit 0 of both the receive and the transmit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | $clog2(MAX_BITS+1) | Word length in bits (0 or out of range selects MAX_BITS) |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| tx_word | input | MAX_BITS | Next word to transmit on MISO |
| rx_word | output | MAX_BITS | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |
| sck_i | input | 1 | SPI clock from the host (asynchronous) |
| cs_n_i | input | 1 | Active-low select from the host (asynchronous) |
| mosi_i | input | 1 | Data from the host (asynchronous) |
| miso_o | output | 1 | Data to the host |
| miso_oe | output | 1 | Output enable for MISO; 0 means high impedance |

## Verification
The assertions assume the following about the host:
- Each SCK phase lasts at least four system-clock cycles, so that no SCK edge is lost in the synchronisers.
- MOSI settles before the rising edge it is sampled on.
- Select changes only while SCK rests at its idle level.
- cfg_len, cfg_lsb_first and tx_word are held stable around their latch points.

The stimulus keeps within these limits. It drives every pin on the falling system-clock edge with SCK phases of exactly four cycles. It opens and closes select only at the idle SCK level. It changes tx_word well inside a word, away from the cycles in which the word is latched. It changes the configuration only while select is inactive.

// File: rtl/spi_at_pkg.sv
package spi_at_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LEAD = 2'd1,
        ST_ACTIVE    = 2'd2
    } tgt_state_t;

endpackage

// File: rtl/spi_at_sync.sv
module spi_at_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/spi_at_edge.sv
module spi_at_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic csn_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_on,
    output logic sel_off
);
    logic sck_d;
    logic csn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign sel_on   = ~csn_s & csn_d;
    assign sel_off  = csn_s & ~csn_d;
endmodule

// File: rtl/spi_at_shift.sv
module spi_at_shift #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1),
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] len,
    input  logic          lsb_first,
    input  logic [W-1:0]  tx_word,
    input  logic          mosi_s,
    input  logic          start,
    input  logic          start_drive,
    input  logic          prime,
    input  logic          adv,
    input  logic          rx_bit,
    input  logic          abort,
    output logic          miso_q,
    output logic [W-1:0]  rx_word,
    output logic          rx_valid
);
    logic [W-1:0]  tx_hold;
    logic [W-1:0]  rx_sr;
    logic [W-1:0]  rx_merged;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] tx_nxt;
    logic [CW-1:0] last_idx;
    logic          miso_r;
    logic [W-1:0]  rx_word_r;
    logic          rx_valid_r;

    // wire position of the idx-th bit on the line
    function automatic logic [IW-1:0] map_pos(input logic [CW-1:0] idx);
        logic [CW-1:0] p;
        p = lsb_first ? idx : (last_idx - idx);
        return p[IW-1:0];
    endfunction

    assign last_idx = len - CW'(1);
    assign tx_nxt   = (tx_cnt == last_idx) ? '0 : tx_cnt + CW'(1);

    always_comb begin
        rx_merged = rx_sr;
        rx_merged[map_pos(rx_cnt)] = mosi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold    <= '0;
            rx_sr      <= '0;
            rx_cnt     <= '0;
            tx_cnt     <= '0;
            miso_r     <= 1'b0;
            rx_word_r  <= '0;
            rx_valid_r <= 1'b0;
        end else begin
            rx_valid_r <= 1'b0;
            if (abort) begin
                rx_sr  <= '0;
                rx_cnt <= '0;
                tx_cnt <= '0;
                miso_r <= 1'b0;
            end else begin
                if (start) begin
                    tx_hold <= tx_word;
                    rx_sr   <= '0;
                    rx_cnt  <= '0;
                    tx_cnt  <= '0;
                    miso_r  <= start_drive ? tx_word[map_pos('0)] : 1'b0;
                end
                if (prime) begin
                    miso_r <= tx_hold[map_pos(tx_cnt)];
                end
                if (rx_bit) begin
                    if (rx_cnt == last_idx) begin
                        rx_word_r  <= rx_merged;
                        rx_valid_r <= 1'b1;
                        tx_hold    <= tx_word;
                        rx_sr      <= '0;
                        rx_cnt     <= '0;
                    end else begin
                        rx_sr  <= rx_merged;
                        rx_cnt <= rx_cnt + CW'(1);
                    end
                end
                if (adv) begin
                    tx_cnt <= tx_nxt;
                    miso_r <= tx_hold[map_pos(tx_nxt)];
                end
            end
        end
    end

    assign miso_q   = miso_r;
    assign rx_word  = rx_word_r;
    assign rx_valid = rx_valid_r;
endmodule

// File: rtl/spi_autopol_target.sv
module spi_autopol_target
    import spi_at_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_lsb_first,
    input  logic [MAX_BITS-1:0] tx_word,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                rx_valid,
    input  logic                sck_i,
    input  logic                cs_n_i,
    input  logic                mosi_i,
    output logic                miso_o,
    output logic                miso_oe
);
    localparam int IDX_W = $clog2(MAX_BITS);

    logic       sck_lvl;
    logic       csn_s;
    logic       mosi_s;
    logic       sck_rise;
    logic       sck_fall;
    logic       sel_on;
    logic       sel_off;
    logic       miso_q;

    tgt_state_t state_q;
    tgt_state_t state_d;
    logic       pend_q;
    logic       pend_d;

    logic       do_start;
    logic       do_drive;
    logic       do_prime;
    logic       do_adv;
    logic       do_rx;
    logic       do_abort;

    logic [LEN_W-1:0] eff_len;

    assign eff_len = (cfg_len == '0 || cfg_len > LEN_W'(MAX_BITS))
                     ? LEN_W'(MAX_BITS) : cfg_len;

    spi_at_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, cs_n_i, mosi_i}),
        .q     ({sck_lvl, csn_s, mosi_s})
    );

    spi_at_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_lvl),
        .csn_s    (csn_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel_on   (sel_on),
        .sel_off  (sel_off)
    );

    spi_at_shift #(.W(MAX_BITS), .CW(LEN_W), .IW(IDX_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .len         (eff_len),
        .lsb_first   (cfg_lsb_first),
        .tx_word     (tx_word),
        .mosi_s      (mosi_s),
        .start       (do_start),
        .start_drive (do_drive),
        .prime       (do_prime),
        .adv         (do_adv),
        .rx_bit      (do_rx),
        .abort       (do_abort),
        .miso_q      (miso_q),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        do_start = 1'b0;
        do_drive = 1'b0;
        do_prime = 1'b0;
        do_adv   = 1'b0;
        do_rx    = 1'b0;
        do_abort = 1'b0;
        if (sel_off) begin
            // T_DESEL
            state_d  = ST_IDLE;
            pend_d   = 1'b0;
            do_abort = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_on) begin
                        do_start = 1'b1;
                        pend_d   = 1'b0;
                        if (!sck_lvl) begin
                            // T_SEL_M0
                            do_drive = 1'b1;
                            state_d  = ST_ACTIVE;
                        end else begin
                            // T_SEL_M3
                            state_d  = ST_WAIT_LEAD;
                        end
                    end
                end
                ST_WAIT_LEAD: begin
                    if (sck_fall) begin
                        // T_LEAD
                        do_prime = 1'b1;
                        state_d  = ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (sck_rise) begin
                        do_rx  = 1'b1;
                        pend_d = 1'b1;
                    end else if (sck_fall && pend_q) begin
                        do_adv = 1'b1;
                        pend_d = 1'b0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        miso_oe = (state_q == ST_ACTIVE);
        miso_o  = miso_oe ? miso_q : 1'b0;
    end
endmodule

// File: rtl/spi_autopol_target_chk.sv
module spi_autopol_target_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic miso_o,
    input logic miso_oe,
    input logic rx_valid,
    input logic sck_rise,
    input logic sck_fall,
    input logic sel_on,
    input logic sck_lvl
);
    logic [1:0] desel_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desel_cnt <= 2'd0;
        end else if (!cs_n_i) begin
            desel_cnt <= 2'd0;
        end else if (desel_cnt != 2'd3) begin
            desel_cnt <= desel_cnt + 2'd1;
        end
    end

    AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_cnt == 2'd3) |-> !miso_oe); // R1

    AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4

    AST_RXV_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sck_rise)); // R4

    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso_o)); // R5

    AST_OE_START_M0: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(miso_oe) && !$past(sck_fall)) |-> $past(sel_on && !sck_lvl)); // R2

    AST_OE_START_M3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(miso_oe) && !$past(sel_on)) |-> $past(sck_fall)); // R3
endmodule

bind spi_autopol_target spi_autopol_target_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .miso_o   (miso_o),
    .miso_oe  (miso_oe),
    .rx_valid (rx_valid),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sel_on   (sel_on),
    .sck_lvl  (sck_lvl)
);

// File: tb/spi_autopol_target_tb_top.sv
module spi_autopol_target_tb_top;
    localparam int MB = 16;
    localparam int LW = $clog2(MB + 1);
    localparam int H  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_len = LW'(8);
    logic          cfg_lsb_first = 1'b0;
    logic [MB-1:0] tx_word = '0;
    logic [MB-1:0] rx_word;
    logic          rx_valid;
    logic          sck_i = 1'b0;
    logic          cs_n_i = 1'b1;
    logic          mosi_i = 1'b0;
    logic          miso_o;
    logic          miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [MB-1:0] exp_q[$];
    logic [MB-1:0] host_w[4];
    logic [MB-1:0] dev_w[5];

    always #4 clk = ~clk;

    spi_autopol_target #(.MAX_BITS(MB)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len       (cfg_len),
        .cfg_lsb_first (cfg_lsb_first),
        .tx_word       (tx_word),
        .rx_word       (rx_word),
        .rx_valid      (rx_valid),
        .sck_i         (sck_i),
        .cs_n_i        (cs_n_i),
        .mosi_i        (mosi_i),
        .miso_o        (miso_o),
        .miso_oe       (miso_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rx_valid", int'(rx_word), 0);
            end else begin
                logic [MB-1:0] e;
                e = exp_q.pop_front();
                check(rx_word == e, "R4/R6/R7 rx_word", int'(rx_word), int'(e));
            end
        end
    end

    // driver: one selection of nw words; abort_bits >= 0 cuts word 0 short
    task automatic burst(input bit m3, input int nw, input int lcfg, input bit lsb,
                         input int abort_bits);
        int L;
        logic [MB-1:0] mask;
        L = (lcfg == 0 || lcfg > MB) ? MB : lcfg;
        mask = (L == MB) ? '1 : ((MB'(1) << L) - MB'(1));
        cfg_len = LW'(lcfg);
        cfg_lsb_first = lsb;
        sck_i = m3;
        waitc(2 * H);
        tx_word = dev_w[0];
        cs_n_i = 1'b0;
        waitc(H);
        tx_word = dev_w[1];
        if (!m3) begin
            // R2: first bit driven before any rising edge
            check(miso_oe == 1'b1, "R2 oe at select", int'(miso_oe), 1);
        end else begin
            // R3: no drive before the first falling edge
            check(miso_oe == 1'b0, "R3 oe before lead edge", int'(miso_oe), 0);
        end
        for (int w = 0; w < nw; w++) begin
            int nb;
            nb = (abort_bits >= 0 && w == 0) ? abort_bits : L;
            if (nb == L) exp_q.push_back(host_w[w] & mask);
            for (int b = 0; b < nb; b++) begin
                int idx;
                logic got;
                idx = lsb ? b : (L - 1 - b);
                if (m3) sck_i = 1'b0;
                mosi_i = host_w[w][idx];
                waitc(H);
                if (b == 0 && w >= 1 && w + 1 < 5) tx_word = dev_w[w + 1];
                got = miso_o;
                check(miso_oe && got == dev_w[w][idx], "R6/R8 miso bit", int'(got),
                      int'(dev_w[w][idx]));
                sck_i = 1'b1;
                waitc(H);
                check(miso_o == got, "R5 miso held in high phase", int'(miso_o), int'(got));
                if (!m3) sck_i = 1'b0;
            end
            if (abort_bits >= 0) break;
        end
        waitc(H);
        cs_n_i = 1'b1;
        waitc(H);
        check(miso_oe == 1'b0, "R1 oe after deselect", int'(miso_oe), 0);
        check(exp_q.size() == 0, "R4/R9 pending words", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        check(miso_oe == 1'b0, "R1 oe after reset", int'(miso_oe), 0);
        check(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);

        // mode 0, 8 bit, msb first, two words back to back (R2 R4 R6 R8)
        host_w = '{16'h00A5, 16'h003C, 16'h0000, 16'h0000};
        dev_w  = '{16'h00BA, 16'h0056, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b0, 2, 8, 1'b0, -1);

        // mode 3, 8 bit, msb first, three words (R3 R8)
        host_w = '{16'h0081, 16'h007E, 16'h00F0, 16'h0000};
        dev_w  = '{16'h00C3, 16'h0011, 16'h00EE, 16'h0000, 16'h0000};
        burst(1'b1, 3, 8, 1'b0, -1);

        // mode 0, 12 bit, lsb first (R6 R7)
        host_w = '{16'hF123, 16'h0ABC, 16'h0000, 16'h0000};
        dev_w  = '{16'h0987, 16'h0F0F, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b0, 2, 12, 1'b1, -1);

        // mode 3, 5 bit, lsb first, upper bits of host word must be dropped (R7)
        host_w = '{16'hFFF5, 16'h000A, 16'h0013, 16'h0000};
        dev_w  = '{16'h0016, 16'h0009, 16'h001F, 16'h0000, 16'h0000};
        burst(1'b1, 3, 5, 1'b1, -1);

        // cfg_len 0 selects 16 bits (R7)
        host_w = '{16'hBEEF, 16'h1234, 16'h0000, 16'h0000};
        dev_w  = '{16'hCAFE, 16'h8001, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b0, 2, 0, 1'b0, -1);

        // abort after 5 bits of an 8-bit word, then a clean word (R9)
        host_w = '{16'h00FF, 16'h0000, 16'h0000, 16'h0000};
        dev_w  = '{16'h00AA, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b0, 1, 8, 1'b0, 5);
        host_w = '{16'h0069, 16'h0000, 16'h0000, 16'h0000};
        dev_w  = '{16'h0096, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b0, 1, 8, 1'b0, -1);

        // abort in mode 3 after 3 bits, then a clean mode 3 word (R9)
        host_w = '{16'h0055, 16'h0000, 16'h0000, 16'h0000};
        dev_w  = '{16'h00E1, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b1, 1, 8, 1'b0, 3);
        host_w = '{16'h00D2, 16'h0000, 16'h0000, 16'h0000};
        dev_w  = '{16'h004B, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
        burst(1'b1, 1, 8, 1'b0, -1);

        waitc(10);
        finish_run();
    end
endmodule